// File: doc/BRIEF.md
# Predicated SIMD Lane Write-Back

This block sits between a wide SIMD execution datapath and the vector register file. Each cycle it can accept one operation result together with the previous contents of the destination register and a set of per-lane exception flags. It decides, lane by lane, whether the result is written, whether the old destination value is kept, or whether the lane is cleared. The merged vector is presented one cycle later with a valid strobe, together with the OR of the exception flags of the lanes that were really written.

The decision is driven by a small file of predicate registers. An operation names one of them by index, and the block reads that register, maps its bits onto lanes according to the element size and the vector length of the operation, and applies the chosen policy (merge or zero-fill) to the lanes whose bit is clear. Index zero is reserved to mean "no predication". The predicate registers are loaded through their own write port.

Top module: `simd_pred_writeback`

## Requirements
- R1: Eight predicate registers of 64 bits each, all zero after reset, are loaded through the write port; a loaded value governs operations issued from the following cycle, while an operation issued in the same cycle as the load of its register still uses the previous value.
- R2: Predicate index 0 disables predication: every lane inside the vector length takes the result, whatever value is stored in register 0.
- R3: Element size codes are 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit; lane i covers result bytes i*S to i*S+S-1 (S the element size in bytes) and is governed by bit i of the selected predicate register.
- R4: Vector length codes are 0 = 128, 1 = 256, 2 = 512 bits; the number of active lanes is the vector length divided by the element size (for example 4, 8 or 16 lanes at 32-bit elements).
- R5: An active lane whose predicate bit is 1 is written with the operation result.
- R6: An active lane whose predicate bit is 0 keeps the old destination value when the zero-fill input is low.
- R7: An active lane whose predicate bit is 0 is written as zero when the zero-fill input is high.
- R8: Predicate bits at positions at or above the active lane count have no effect on the written data or flags.
- R9: All output bytes above the vector length are zero, in both merge and zero-fill modes.
- R10: The flag output is the OR of the 5-bit flag groups of the active lanes whose predicate bit is 1 (or of all active lanes under index 0); lane i's group is at op_flags bits 5*i+4 down to 5*i; other lanes contribute nothing.
- R11: The write-back is registered: an operation presented with op_vld produces wb_vld, wb_data and wb_flags after exactly one clock edge; wb_vld is low in a cycle following no operation, and after reset wb_vld, wb_data and wb_flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mwr_en | input | 1 | Predicate register load strobe |
| mwr_idx | input | 3 | Predicate register to load |
| mwr_data | input | 64 | Value loaded into the predicate register |
| op_vld | input | 1 | Operation present this cycle |
| op_result | input | 512 | Result vector from the datapath |
| op_old | input | 512 | Previous destination register contents |
| op_flags | input | 320 | Per-lane exception flags, 5 bits per lane |
| pred_idx | input | 3 | Predicate register selected; 0 means none |
| elem_sz | input | 2 | Element size code |
| vec_len | input | 2 | Vector length code |
| zero_fill | input | 1 | 1: masked lanes cleared; 0: masked lanes keep old value |
| wb_vld | output | 1 | Write-back valid |
| wb_data | output | 512 | Vector to write into the register file |
| wb_flags | output | 5 | OR of the flags of written lanes |

## Verification
The assertions assume the vector length code never takes the reserved value 3 while an operation is presented, and that the input buses are at known values whenever op_vld is high; the bench only ever drives the three legal length codes and fills every bus with full patterns before raising op_vld. Assertions that compare the output against the whole result or old vector assume a 512-bit operation, which the stimulus exercises in every sweep pass alongside the shorter lengths. The bench sweeps every predicate index, element size, length and fill mode against predicate registers holding random, all-ones and all-zero patterns, and separately issues an operation in the same cycle as a load of its own predicate register.

// File: rtl/lane_pred_pkg.sv
package lane_pred_pkg;
   typedef enum logic [1:0] {
      ELEM_8  = 2'd0,
      ELEM_16 = 2'd1,
      ELEM_32 = 2'd2,
      ELEM_64 = 2'd3
   } elem_sz_e;

   typedef enum logic [1:0] {
      VL_128  = 2'd0,
      VL_256  = 2'd1,
      VL_512  = 2'd2,
      VL_RSVD = 2'd3
   } vec_len_e;

   // bytes in the narrowest vector length
   localparam int unsigned BASE_BYTES = 16;
endpackage

// File: rtl/pred_mask_file.sv
module pred_mask_file #(
   parameter int unsigned NUM_REGS = 8,
   parameter int unsigned REG_W    = 64,
   localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [REG_W-1:0] wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [REG_W-1:0] rd_data
);
   logic [REG_W-1:0] regs [NUM_REGS];

   if (NUM_REGS < 2 || (1 << IDX_W) != NUM_REGS) begin : g_bad_depth
      $error("pred_mask_file: NUM_REGS must be a power of two of at least 2");
   end

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs[r] <= '0;
         else if (wr_en && wr_idx == IDX_W'(r))
            regs[r] <= wr_data;
      end
   end

   // read is combinational: a load in this cycle becomes visible next cycle
   assign rd_data = regs[rd_idx];

   assert_load_visible_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en ##1 (rd_idx == $past(wr_idx)) |-> rd_data == $past(wr_data));
endmodule

// File: rtl/pred_lane_expand.sv
module pred_lane_expand
   import lane_pred_pkg::*;
#(
   parameter int unsigned VEC_W = 512,
   localparam int unsigned NB   = VEC_W / 8,
   localparam int unsigned BI_W = $clog2(NB),
   localparam int unsigned CNT_W = BI_W + 1
) (
   input  logic [NB-1:0] mask_word,
   input  logic          pred_off,
   input  elem_sz_e      elem_sz,
   input  vec_len_e      vec_len,
   output logic [NB-1:0] byte_take,
   output logic [NB-1:0] byte_live,
   output logic [NB-1:0] lane_act
);
   logic [CNT_W-1:0] live_bytes;
   logic [CNT_W-1:0] lane_cnt;

   assign live_bytes = CNT_W'(BASE_BYTES) << vec_len;
   assign lane_cnt   = live_bytes >> elem_sz;

   for (genvar b = 0; b < NB; b++) begin : g_byte
      logic [BI_W-1:0] lane_of;
      assign lane_of      = BI_W'(b) >> elem_sz;
      assign byte_live[b] = CNT_W'(b) < live_bytes;
      assign byte_take[b] = byte_live[b] && (pred_off || mask_word[lane_of]);
   end

   for (genvar l = 0; l < NB; l++) begin : g_lane
      assign lane_act[l] = (CNT_W'(l) < lane_cnt) && (pred_off || mask_word[l]);
   end
endmodule

// File: rtl/pred_merge_stage.sv
module pred_merge_stage #(
   parameter int unsigned VEC_W = 512,
   parameter int unsigned FLG_W = 5,
   localparam int unsigned NB   = VEC_W / 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_vld,
   input  logic [VEC_W-1:0]    result,
   input  logic [VEC_W-1:0]    old_val,
   input  logic [NB*FLG_W-1:0] lane_flags,
   input  logic [NB-1:0]       byte_take,
   input  logic [NB-1:0]       byte_live,
   input  logic [NB-1:0]       lane_act,
   input  logic                zero_fill,
   output logic                out_vld,
   output logic [VEC_W-1:0]    out_data,
   output logic [FLG_W-1:0]    out_flags
);
   logic [VEC_W-1:0] data_nxt;
   logic [FLG_W-1:0] flg_nxt;

   for (genvar b = 0; b < NB; b++) begin : g_sel
      always_comb begin
         if (byte_take[b])
            data_nxt[b*8 +: 8] = result[b*8 +: 8];
         else if (byte_live[b] && !zero_fill)
            data_nxt[b*8 +: 8] = old_val[b*8 +: 8];
         else
            data_nxt[b*8 +: 8] = 8'h00;
      end
   end

   always_comb begin
      flg_nxt = '0;
      for (int l = 0; l < NB; l++)
         if (lane_act[l])
            flg_nxt = flg_nxt | lane_flags[l*FLG_W +: FLG_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld   <= 1'b0;
         out_data  <= '0;
         out_flags <= '0;
      end else begin
         out_vld <= in_vld;
         if (in_vld) begin
            out_data  <= data_nxt;
            out_flags <= flg_nxt;
         end
      end
   end

   assert_flag_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && lane_act == '0) |=> out_flags == '0);

   assert_dead_top_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && !byte_live[NB-1]) |=> out_data[VEC_W-1 -: 8] == 8'h00);

   assert_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_vld);

   assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> !out_vld);
endmodule

// File: rtl/simd_pred_writeback.sv
module simd_pred_writeback
   import lane_pred_pkg::*;
#(
   parameter int unsigned VEC_W    = 512,
   parameter int unsigned NUM_PRED = 8,
   parameter int unsigned FLG_W    = 5,
   localparam int unsigned NB      = VEC_W / 8,
   localparam int unsigned PI_W    = $clog2(NUM_PRED)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                mwr_en,
   input  logic [PI_W-1:0]     mwr_idx,
   input  logic [NB-1:0]       mwr_data,
   input  logic                op_vld,
   input  logic [VEC_W-1:0]    op_result,
   input  logic [VEC_W-1:0]    op_old,
   input  logic [NB*FLG_W-1:0] op_flags,
   input  logic [PI_W-1:0]     pred_idx,
   input  logic [1:0]          elem_sz,
   input  logic [1:0]          vec_len,
   input  logic                zero_fill,
   output logic                wb_vld,
   output logic [VEC_W-1:0]    wb_data,
   output logic [FLG_W-1:0]    wb_flags
);
   if (VEC_W != 512) begin : g_bad_width
      $error("simd_pred_writeback: length codes 0..2 require VEC_W = 512");
   end
   if (FLG_W < 1) begin : g_bad_flags
      $error("simd_pred_writeback: FLG_W must be at least 1");
   end

   logic [NB-1:0] sel_mask;
   logic [NB-1:0] byte_take;
   logic [NB-1:0] byte_live;
   logic [NB-1:0] lane_act;
   logic          pred_off;

   assign pred_off = (pred_idx == '0);

   pred_mask_file #(.NUM_REGS(NUM_PRED), .REG_W(NB)) u_masks (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (mwr_en),
      .wr_idx  (mwr_idx),
      .wr_data (mwr_data),
      .rd_idx  (pred_idx),
      .rd_data (sel_mask)
   );

   pred_lane_expand #(.VEC_W(VEC_W)) u_expand (
      .mask_word (sel_mask),
      .pred_off  (pred_off),
      .elem_sz   (elem_sz_e'(elem_sz)),
      .vec_len   (vec_len_e'(vec_len)),
      .byte_take (byte_take),
      .byte_live (byte_live),
      .lane_act  (lane_act)
   );

   pred_merge_stage #(.VEC_W(VEC_W), .FLG_W(FLG_W)) u_merge (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_vld     (op_vld),
      .result     (op_result),
      .old_val    (op_old),
      .lane_flags (op_flags),
      .byte_take  (byte_take),
      .byte_live  (byte_live),
      .lane_act   (lane_act),
      .zero_fill  (zero_fill),
      .out_vld    (wb_vld),
      .out_data   (wb_data),
      .out_flags  (wb_flags)
   );

   assert_legal_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
      op_vld |-> vec_len != 2'd3);

   assert_no_pred_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_vld && pred_idx == '0 && vec_len == 2'd2) |=> wb_data == $past(op_result));

   assert_all_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_vld && vec_len == 2'd2 && elem_sz == 2'd0 && &sel_mask)
      |=> wb_data == $past(op_result));

   assert_merge_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_vld && pred_idx != '0 && vec_len == 2'd2 && !zero_fill && sel_mask == '0)
      |=> wb_data == $past(op_old));

   assert_zero_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_vld && pred_idx != '0 && zero_fill && sel_mask == '0) |=> wb_data == '0);
endmodule

// File: tb/simd_pred_writeback_test.sv
module simd_pred_writeback_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         mwr_en = 1'b0;
   logic [2:0]   mwr_idx = '0;
   logic [63:0]  mwr_data = '0;
   logic         op_vld = 1'b0;
   logic [511:0] op_result = '0;
   logic [511:0] op_old = '0;
   logic [319:0] op_flags = '0;
   logic [2:0]   pred_idx = '0;
   logic [1:0]   elem_sz = '0;
   logic [1:0]   vec_len = '0;
   logic         zero_fill = 1'b0;
   logic         wb_vld;
   logic [511:0] wb_data;
   logic [4:0]   wb_flags;

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;
   logic [63:0] mref [8];

   always #2.5 clk = ~clk;

   simd_pred_writeback uut (
      .clk(clk), .rst_n(rst_n), .mwr_en(mwr_en), .mwr_idx(mwr_idx),
      .mwr_data(mwr_data), .op_vld(op_vld), .op_result(op_result),
      .op_old(op_old), .op_flags(op_flags), .pred_idx(pred_idx),
      .elem_sz(elem_sz), .vec_len(vec_len), .zero_fill(zero_fill),
      .wb_vld(wb_vld), .wb_data(wb_data), .wb_flags(wb_flags)
   );

   function automatic logic [511:0] rnd512();
      logic [511:0] v;
      for (int w = 0; w < 16; w++) v[w*32 +: 32] = $urandom;
      return v;
   endfunction

   function automatic logic [319:0] rnd320();
      logic [319:0] v;
      for (int w = 0; w < 10; w++) v[w*32 +: 32] = $urandom;
      return v;
   endfunction

   task automatic chk_bit(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %b expected %b", req, act, exp);
      end
   endtask

   task automatic chk_data(input string req, input logic [511:0] act, input logic [511:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic chk_flags(input string req, input logic [4:0] act, input logic [4:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %b expected %b", req, act, exp);
      end
   endtask

   // load a predicate register; called at a falling edge, returns at the next
   task automatic load_mask(input int idx, input logic [63:0] val);
      mwr_en = 1'b1; mwr_idx = 3'(idx); mwr_data = val;
      @(negedge clk);
      mwr_en = 1'b0;
      mref[idx] = val;
   endtask

   // issue one operation, optionally loading a register in the same cycle
   task automatic run_op(input int pi, input int es, input int vl, input bit z,
                         input bit ld, input int ld_idx, input logic [63:0] ld_val);
      logic [511:0] res, old, exp_d;
      logic [319:0] fl;
      logic [4:0]   exp_f;
      int vbytes, lanes, esz;
      res = rnd512(); old = rnd512(); fl = rnd320();
      vbytes = 16 << vl;
      esz = 1 << es;
      lanes = vbytes / esz;
      exp_d = '0;
      exp_f = '0;
      for (int b = 0; b < 64; b++) begin
         int ln;
         ln = b / esz;
         if (b < vbytes) begin
            if (pi == 0 || mref[pi][ln]) exp_d[b*8 +: 8] = res[b*8 +: 8];
            else if (!z) exp_d[b*8 +: 8] = old[b*8 +: 8];
         end
      end
      for (int l = 0; l < lanes; l++)
         if (pi == 0 || mref[pi][l]) exp_f = exp_f | fl[l*5 +: 5];
      op_vld = 1'b1; op_result = res; op_old = old; op_flags = fl;
      pred_idx = 3'(pi); elem_sz = 2'(es); vec_len = 2'(vl); zero_fill = z;
      if (ld) begin
         mwr_en = 1'b1; mwr_idx = 3'(ld_idx); mwr_data = ld_val;
      end
      @(negedge clk);
      op_vld = 1'b0; mwr_en = 1'b0;
      if (ld) mref[ld_idx] = ld_val;
      chk_bit("R11 valid after one edge", wb_vld, 1'b1);
      // lane mapping, take/merge/zero, ignored high bits, cleared tail
      chk_data("R3 R4 R5 R6 R7 R8 R9 data", wb_data, exp_d);
      chk_flags("R10 flags", wb_flags, exp_f);
   endtask

   task automatic sweep();
      for (int pi = 0; pi < 8; pi++)
         for (int es = 0; es < 4; es++)
            for (int vl = 0; vl < 3; vl++)
               for (int z = 0; z < 2; z++)
                  run_op(pi, es, vl, z[0], 1'b0, 0, '0);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [511:0] held;
      for (int i = 0; i < 8; i++) mref[i] = '0;
      repeat (3) @(negedge clk);
      // R11: reset state
      chk_bit("R11 reset valid", wb_vld, 1'b0);
      chk_data("R11 reset data", wb_data, '0);
      chk_flags("R11 reset flags", wb_flags, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: registers start at zero, so index 3 masks every lane
      run_op(3, 2, 2, 1'b0, 1'b0, 0, '0);

      // pass 1: register 0 holds a pattern that must be ignored (R2)
      load_mask(0, 64'h0000_0000_0000_0000);
      load_mask(1, 64'hFFFF_FFFF_FFFF_FFFF);
      load_mask(2, 64'h0000_0000_0000_0000);
      for (int i = 3; i < 8; i++) load_mask(i, {$urandom, $urandom});
      sweep();

      // pass 2: new random content, high bits set beyond lane counts (R8)
      load_mask(0, 64'h5A5A_0F0F_A5A5_F0F0);
      load_mask(1, 64'hFFFF_0000_0000_00A5);
      load_mask(2, 64'h8000_0000_0000_0000);
      for (int i = 3; i < 8; i++) load_mask(i, {$urandom, $urandom});
      sweep();

      // R1: load in the same cycle as a use sees the old value, then the new
      run_op(5, 0, 2, 1'b0, 1'b1, 5, ~mref[5]);
      run_op(5, 0, 2, 1'b0, 1'b0, 0, '0);
      run_op(6, 1, 1, 1'b1, 1'b1, 6, 64'h0);
      run_op(6, 1, 1, 1'b1, 1'b0, 0, '0);

      // R11: idle cycle drops valid and holds data
      held = wb_data;
      @(negedge clk);
      chk_bit("R11 idle valid low", wb_vld, 1'b0);
      chk_data("R11 idle data held", wb_data, held);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule